// File: doc/BRIEF.md
# Mode-Selectable Simple Dual-Port Memory

This block is a single-clock memory with one write port and one read port. Writes are synchronous. The caller holds a write-enable level, an address and a data word through a cycle, and the array takes them on the rising clock edge. No separately timed write pulse is needed. The array can start with contents given by a packed parameter image, so a table needs no loader logic.

A parameter selects how reads are timed, and each choice trades latency against timing margin:
- **Pipelined mode** samples the array on a rising edge and then adds an output register.
- **Flow-through mode** samples the array once on a rising edge.
- **Half-cycle mode** samples the array on the falling edge. Read data for an address driven in a cycle is then ready before that cycle ends.

In every mode the read output reads zero while reset is applied. It stays at zero until the first completed read, whatever the preload holds.

Top module: `dpram_modes`

## Requirements
- R1: When `wr_en` is high at a rising edge, `wr_data` is stored at `wr_addr`. When `wr_en` is low at that edge, no location changes.
- R2: After reset, and before any write to it, a read of address i returns bits [i*DATA_W +: DATA_W] of `INIT_IMAGE`. Reset does not clear the array.
- R3: With `READ_MODE` = `RD_PIPELINED` (2'd0), a read issued in cycle n appears on `rd_data` after the second rising edge that follows.
- R4: With `READ_MODE` = `RD_FLOWTHRU` (2'd1), a read issued in cycle n appears on `rd_data` after the next rising edge.
- R5: With `READ_MODE` = `RD_HALFCYCLE` (2'd2), the read address and read enable are sampled on the falling edge inside cycle n. The data is on `rd_data` before cycle n ends.
- R6: `rd_data` is zero while `rst_n` is low. It stays zero until the first read completes, even when the preload of the address presented is nonzero (address 0 is preloaded with 8'hFF in the bench).
- R7: A read and a write of the same address in the same cycle return the value held before that write.
- R8: In a cycle with `rd_en` low, `rd_data` keeps its last value. This holds even if the location last read is rewritten.
- R9: Data written in cycle n is returned by a read of that address issued in cycle n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on the rising edge, half-cycle reads on the falling edge |
| rst_n | input | 1 | Active-low asynchronous reset of the read path |
| wr_en | input | 1 | Write enable level |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read enable level |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data |

## Verification
Each kind of internal fault shows up at `rd_data` at a predictable time:
- A wrong array word appears at the port the first time that address is read: after two edges, one edge or half an edge, depending on the mode.
- A pipeline stage that loads while idle, or ignores its enable, breaks the held value in the very next idle cycle.
- A write-ordering fault returns the new word one edge early, in the same-address read-and-write cycle.
- A read path that is not cleared shows the preloaded 8'hFF at address 0 while reset is low.

All three modes are driven with the same stimulus, so a fault limited to one mode stands out against the other two.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        RD_PIPELINED = 2'd0,
        RD_FLOWTHRU  = 2'd1,
        RD_HALFCYCLE = 2'd2
    } rd_mode_e;

endpackage

// File: rtl/dpram_store.sv
module dpram_store #(
    parameter int                           DATA_W     = 8,
    parameter int                           ADDR_W     = 4,
    parameter logic [(1<<ADDR_W)*DATA_W-1:0] INIT_IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] = INIT_IMAGE[i*DATA_W +: DATA_W];
        end
    end

    // the array itself is the write-side register: address, data and enable
    // are all taken on the rising edge
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_word = mem_q[rd_addr];

    AST_WR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data)); // R1

    AST_WR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> mem_q[$past(wr_addr)] == $past(mem_q[wr_addr])); // R1

endmodule

// File: rtl/dpram_rd_path.sv
module dpram_rd_path #(
    parameter int DATA_W  = 8,
    parameter int STAGES  = 1,
    parameter bit FALLING = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    generate
        if (STAGES == 2) begin : g_two
            typedef struct packed {
                logic              en1;
                logic [DATA_W-1:0] d1;
                logic [DATA_W-1:0] d2;
            } pipe_t;

            pipe_t pipe_d, pipe_q;

            always_comb begin
                pipe_d     = pipe_q;
                pipe_d.en1 = en;
                if (en) begin
                    pipe_d.d1 = din;
                end
                if (pipe_q.en1) begin
                    pipe_d.d2 = pipe_q.d1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q <= pipe_d;
                end
            end

            assign dout = pipe_q.d2;

            AST_PIPE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !pipe_q.en1 |=> $stable(dout)); // R8

        end else begin : g_one
            typedef struct packed {
                logic [DATA_W-1:0] d1;
            } one_t;

            one_t one_d, one_q;

            always_comb begin
                one_d = one_q;
                if (en) begin
                    one_d.d1 = din;
                end
            end

            if (FALLING) begin : g_fall
                always_ff @(negedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        one_q <= '0;
                    end else begin
                        one_q <= one_d;
                    end
                end

                AST_FALL_IDLE_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
                    !en |=> $stable(dout)); // R8
            end else begin : g_rise
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        one_q <= '0;
                    end else begin
                        one_q <= one_d;
                    end
                end

                AST_RISE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                    !en |=> $stable(dout)); // R8
            end

            assign dout = one_q.d1;
        end
    endgenerate

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RST_CLEAR: assert (dout == '0); // R6
        end
    end

endmodule

// File: rtl/dpram_modes.sv
module dpram_modes
    import dpram_pkg::*;
#(
    parameter int                           DATA_W     = 8,
    parameter int                           ADDR_W     = 4,
    parameter rd_mode_e                     READ_MODE  = RD_PIPELINED,
    parameter logic [(1<<ADDR_W)*DATA_W-1:0] INIT_IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int RD_STAGES  = (READ_MODE == RD_PIPELINED) ? 2 : 1;
    localparam bit RD_FALLING = (READ_MODE == RD_HALFCYCLE);

    logic [DATA_W-1:0] rd_word;

    dpram_store #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .INIT_IMAGE (INIT_IMAGE)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    dpram_rd_path #(
        .DATA_W  (DATA_W),
        .STAGES  (RD_STAGES),
        .FALLING (RD_FALLING)
    ) u_rd_path (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rd_en),
        .din   (rd_word),
        .dout  (rd_data)
    );

    generate
        if (READ_MODE == RD_PIPELINED) begin : g_chk_pipe
            AST_PIPE_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
                rd_en |=> ##1 rd_data == $past(rd_word, 2)); // R3
        end else if (READ_MODE == RD_FLOWTHRU) begin : g_chk_flow
            AST_FLOW_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
                rd_en |=> rd_data == $past(rd_word)); // R4
            AST_FLOW_OLD_ON_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && wr_en && rd_addr == wr_addr && rd_word != wr_data)
                |=> rd_data != $past(wr_data)); // R7
        end else begin : g_chk_half
            AST_HALF_SAME_CYCLE: assert property (@(negedge clk) disable iff (!rst_n)
                rd_en |=> rd_data == $past(rd_word)); // R5
        end
    endgenerate

endmodule

// File: tb/dpram_modes_test.sv
module dpram_modes_test;
    import dpram_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int AW         = 4;
    localparam int DEPTH      = 1 << AW;

    function automatic logic [DEPTH*DW-1:0] build_img();
        logic [DEPTH*DW-1:0] img;
        img = '0;
        for (int i = 0; i < DEPTH; i++) begin
            img[i*DW +: DW] = (i == 0) ? 8'hFF : 8'((i * 37 + 3) & 8'hFF);
        end
        return img;
    endfunction

    localparam logic [DEPTH*DW-1:0] IMG = build_img();

    logic          clk     = 1'b0;
    logic          rst_n   = 1'b1;
    logic          wr_en   = 1'b0;
    logic          rd_en   = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] out_pipe, out_flow, out_half;

    dpram_modes #(.DATA_W(DW), .ADDR_W(AW), .READ_MODE(RD_PIPELINED), .INIT_IMAGE(IMG)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(out_pipe));
    dpram_modes #(.DATA_W(DW), .ADDR_W(AW), .READ_MODE(RD_FLOWTHRU), .INIT_IMAGE(IMG)) uut_flow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(out_flow));
    dpram_modes #(.DATA_W(DW), .ADDR_W(AW), .READ_MODE(RD_HALFCYCLE), .INIT_IMAGE(IMG)) uut_half (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(out_half));

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int            due;
        logic [DW-1:0] data;
    } exp_t;

    exp_t          sb_q [3][$];
    logic [DW-1:0] cur_exp [3];
    logic [DW-1:0] ref_mem [DEPTH];
    int            lat [3] = '{2, 1, 0};
    int            step_no = 0;
    int            n_cmp   = 0;
    int            n_bad   = 0;
    bit            done    = 1'b0;
    string         step_tag = "R6";
    event          sample_ev;

    function automatic string mode_req(int m);
        return (m == 0) ? "R3 pipelined" : (m == 1) ? "R4 flow-through" : "R5 half-cycle";
    endfunction

    // monitor: retire due items, compare every mode every step
    always @(sample_ev) begin
        for (int m = 0; m < 3; m++) begin
            logic [DW-1:0] got;
            exp_t          it;
            while (sb_q[m].size() > 0 && sb_q[m][0].due <= step_no) begin
                it = sb_q[m].pop_front();
                cur_exp[m] = it.data;
            end
            got = (m == 0) ? out_pipe : (m == 1) ? out_flow : out_half;
            n_cmp++;
            if (got !== cur_exp[m]) begin
                n_bad++;
                $display("FAIL %s [%s] step %0d: got %h expected %h",
                         step_tag, mode_req(m), step_no, got, cur_exp[m]);
            end
        end
    end

    // driver: one cycle of stimulus, expected items pushed into the scoreboard
    task automatic step(input bit we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input bit re, input logic [AW-1:0] ra, input string tag);
        step_tag = tag;
        wr_en    = we;
        wr_addr  = wa;
        wr_data  = wd;
        rd_en    = re;
        rd_addr  = ra;
        if (re) begin
            for (int m = 0; m < 3; m++) begin
                sb_q[m].push_back('{due: step_no + lat[m], data: ref_mem[ra]});
            end
        end
        if (we) begin
            ref_mem[wa] = wd;   // after the read: old value on collision (R7)
        end
        #(CLK_PERIOD - 2);
        -> sample_ev;
        @(posedge clk);
        #1;
        step_no++;
    endtask

    task automatic idle(input int n, input logic [AW-1:0] ra, input string tag);
        for (int k = 0; k < n; k++) begin
            step(1'b0, '0, '0, 1'b0, ra, tag);
        end
    endtask

    task automatic reset_cycle(input string tag);
        rst_n = 1'b0;
        for (int m = 0; m < 3; m++) begin
            sb_q[m].delete();
            cur_exp[m] = '0;
        end
        idle(2, 4'd0, tag);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = IMG[i*DW +: DW];
        end
        for (int m = 0; m < 3; m++) begin
            cur_exp[m] = '0;
        end
        #2;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        reset_cycle("R6 reset");
        // zero output although address 0 holds 8'hFF
        idle(2, 4'd0, "R6 no read yet");
        // preload image, back-to-back reads show each latency
        step(1'b0, '0, '0, 1'b1, 4'd0, "R2 preload addr0");
        step(1'b0, '0, '0, 1'b1, 4'd1, "R2 preload addr1");
        step(1'b0, '0, '0, 1'b1, 4'd2, "R2 preload addr2");
        idle(2, 4'd2, "R3 R4 R5 drain");
        // writes and next-cycle visibility
        step(1'b1, 4'd3, 8'hAA, 1'b0, 4'd0, "R1 write");
        step(1'b1, 4'd4, 8'hBB, 1'b1, 4'd3, "R9 read after write");
        step(1'b0, '0, '0, 1'b1, 4'd4, "R9 read after write");
        idle(2, 4'd4, "R9 drain");
        // masked write leaves location unchanged
        step(1'b0, 4'd5, 8'h00, 1'b0, 4'd0, "R1 masked write");
        step(1'b0, '0, '0, 1'b1, 4'd5, "R1 masked write readback");
        idle(2, 4'd5, "R1 drain");
        // same-address collision returns old data
        step(1'b1, 4'd7, 8'hC3, 1'b1, 4'd7, "R7 collision");
        step(1'b0, '0, '0, 1'b1, 4'd7, "R9 after collision");
        idle(2, 4'd7, "R7 drain");
        // hold with read enable low, even after rewrite of the read location
        step(1'b0, '0, '0, 1'b1, 4'd9, "R8 read");
        idle(3, 4'd10, "R8 hold");
        step(1'b1, 4'd9, 8'h77, 1'b0, 4'd9, "R8 rewrite while idle");
        idle(2, 4'd11, "R8 hold");
        // latency under a streaming and a gapped pattern
        step(1'b0, '0, '0, 1'b1, 4'd12, "R3 R4 R5 stream");
        step(1'b1, 4'd13, 8'h3C, 1'b1, 4'd13, "R7 stream collision");
        step(1'b0, '0, '0, 1'b1, 4'd14, "R3 R4 R5 stream");
        step(1'b0, '0, '0, 1'b1, 4'd15, "R3 R4 R5 stream");
        step(1'b0, '0, '0, 1'b0, 4'd1, "R8 gap");
        step(1'b0, '0, '0, 1'b1, 4'd13, "R9 stream readback");
        step(1'b0, '0, '0, 1'b0, 4'd6, "R8 gap");
        step(1'b0, '0, '0, 1'b1, 4'd9, "R8 rewritten value");
        idle(3, 4'd9, "R3 R4 R5 drain");
        // second reset: output cleared, array contents kept
        reset_cycle("R6 mid-run reset");
        idle(2, 4'd3, "R6 no read after reset");
        step(1'b0, '0, '0, 1'b1, 4'd3, "R2 array kept over reset");
        step(1'b0, '0, '0, 1'b1, 4'd0, "R2 preload addr0 again");
        idle(3, 4'd0, "R2 drain");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1..R9 run: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule